// File: doc/BRIEF.md
# Page Commit Unit

This block sits behind the serial command decoder of a non-volatile memory model and turns a page-program command into an array update. The decoder announces a program command with a start address. It then passes each complete data byte, and finally reports that chip select has gone high, together with a flag that says whether that edge fell exactly between bytes. The block fills a 128-entry page buffer. The low address bits of each byte wrap inside the page, so a stream longer than one page overwrites its own earlier bytes.

A command is accepted only when the write enable latch input is set and the addressed page lies outside the region selected by the block-protect level. A byte-aligned chip-select rise after at least one byte starts a self-timed busy period of a parameterised number of clocks. During the first 128 clocks of that period the block drives the page, one byte per clock, into a synchronous write port of the array. In the last busy clock it pulses a request that clears the write enable latch. A misaligned rise, or a rise with no data, abandons the command. In that case the array is untouched and the latch is not cleared.

Top module: `page_commit_unit`

## Requirements
- R1: After reset, busy, wel_clear and mem_we are all low.
- R2: A wr_start while wel is low is dropped: no byte is taken, and no busy period or array change follows the chip-select rise.
- R3: Protection by bp_level on the page address: 0 protects nothing, 1 protects the pages whose two top address bits are 11, 2 protects the pages whose top address bit is 1, and 3 protects every page. A command to a protected page is dropped with no busy period and no array change.
- R4: Data byte k of a command is stored at page offset (start_addr[6:0] + k) mod 128. The page bits start_addr[ADDR_W-1:7] stay fixed for the whole command.
- R5: When more than 128 bytes arrive, each later byte replaces the one held at the same page offset.
- R6: busy rises on the clock after a cs_rise that arrives with at_byte_edge high, in an accepted command that has received at least one byte.
- R7: A cs_rise with at_byte_edge low, or with no byte received, ends the command with no busy period, no array write and no wel_clear pulse.
- R8: busy stays high for exactly BUSY_CYCLES consecutive clocks.
- R9: mem_we is high only while busy, for exactly 128 clocks per commit, writing offsets 0 to 127 of the page in that order.
- R10: wel_clear is a single-clock pulse in the last busy clock of a commit, and is never high at any other time.
- R11: wr_start, byte_valid and cs_rise that arrive while busy have no effect on the committed page, the busy length or any other page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wel | input | 1 | Current write enable latch state |
| bp_level | input | 2 | Block-protect level (see R3) |
| wr_start | input | 1 | Program command decoded, start address valid |
| start_addr | input | ADDR_W | Byte address of the first data byte |
| byte_valid | input | 1 | A complete data byte is on byte_data |
| byte_data | input | DATA_W | Data byte |
| cs_rise | input | 1 | Chip select went high |
| at_byte_edge | input | 1 | The chip-select rise fell exactly on a byte boundary |
| busy | output | 1 | Self-timed write in progress |
| wel_clear | output | 1 | Request to reset the write enable latch |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
The hardest case to reach is new command traffic that arrives in the middle of a busy period. A correct decoder would never send it, yet a fault there would silently corrupt the buffer that is being drained. The stimulus injects a full wr_start, byte and aligned chip-select rise partway through a commit. It then checks both the committed page and the page named by the intruding command. Random commands also mix page offsets, lengths past 128, protect levels, latch states and misaligned rises, and each result is compared against a model of the whole array.

// File: rtl/page_commit_unit.sv
module page_commit_unit #(
  parameter int ADDR_W      = 17,
  parameter int PAGE_W      = 7,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel,
  input  logic [1:0]        bp_level,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              cs_rise,
  input  logic              at_byte_edge,
  output logic              busy,
  output logic              wel_clear,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int HI_W       = ADDR_W - PAGE_W;
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BUSY_CYCLES - 1);
  localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_BUSY} state_t;

  state_t            state;
  logic [HI_W-1:0]   page_hi;
  logic [PAGE_W-1:0] ptr;
  logic              have_byte;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] buf_q [PAGE_BYTES];

  function automatic logic page_locked(input logic [HI_W-1:0] hi, input logic [1:0] lvl);
    case (lvl)
      2'd1:    return hi[HI_W-1:HI_W-2] == 2'b11;
      2'd2:    return hi[HI_W-1];
      2'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  wire start_ok = wr_start && wel && !page_locked(start_addr[ADDR_W-1:PAGE_W], bp_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      page_hi   <= '0;
      ptr       <= '0;
      have_byte <= 1'b0;
      cnt       <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_ok) begin
          state     <= S_FILL;
          page_hi   <= start_addr[ADDR_W-1:PAGE_W];
          ptr       <= start_addr[PAGE_W-1:0];
          have_byte <= 1'b0;
        end
        S_FILL: begin
          if (byte_valid) begin
            ptr       <= ptr + 1'b1;
            have_byte <= 1'b1;
          end
          if (cs_rise) begin
            cnt   <= '0;
            state <= (at_byte_edge && have_byte) ? S_BUSY : S_IDLE;
          end
        end
        S_BUSY: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_CNT) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_FILL && byte_valid && !cs_rise) buf_q[ptr] <= byte_data;
  end

  assign busy      = (state == S_BUSY);
  assign wel_clear = busy && (cnt == LAST_CNT);
  assign mem_we    = busy && (cnt < PAGE_CNT);
  assign mem_addr  = {page_hi, cnt[PAGE_W-1:0]};
  assign mem_wdata = buf_q[cnt[PAGE_W-1:0]];
endmodule

module page_commit_unit_chk #(
  parameter int ADDR_W      = 17,
  parameter int PAGE_W      = 7,
  parameter int BUSY_CYCLES = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_rise,
  input logic              at_byte_edge,
  input logic              busy,
  input logic              wel_clear,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  localparam int RUN_W = $clog2(BUSY_CYCLES + 1) + 1;
  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  p_we_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> busy);
  p_clear_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n) wel_clear |-> busy);
  p_clear_last_r10: assert property (@(posedge clk) disable iff (!rst_n) wel_clear |=> !busy);
  p_start_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise && at_byte_edge));
  p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == RUN_W'(BUSY_CYCLES));
  p_busy_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= RUN_W'(BUSY_CYCLES));
  p_page_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:PAGE_W]));
endmodule

bind page_commit_unit page_commit_unit_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .at_byte_edge(at_byte_edge),
  .busy(busy), .wel_clear(wel_clear), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/page_commit_unit_tb_top.sv
module page_commit_unit_tb_top;
  localparam int ADDR_W = 10;
  localparam int PAGE_W = 7;
  localparam int DATA_W = 8;
  localparam int BUSY_CYCLES = 150;
  localparam int MEM_N = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wel = 1'b0;
  logic [1:0] bp_level = 2'd0;
  logic wr_start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic byte_valid = 1'b0;
  logic [DATA_W-1:0] byte_data = '0;
  logic cs_rise = 1'b0;
  logic at_byte_edge = 1'b0;
  logic busy, wel_clear, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  int checks = 0;
  int failures = 0;
  logic [7:0] dut_mem [MEM_N];
  logic [7:0] exp_mem [MEM_N];
  logic [7:0] pbuf [128];

  always #5 clk = ~clk;

  page_commit_unit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) dut_i (
    .clk(clk), .rst_n(rst_n), .wel(wel), .bp_level(bp_level), .wr_start(wr_start),
    .start_addr(start_addr), .byte_valid(byte_valid), .byte_data(byte_data),
    .cs_rise(cs_rise), .at_byte_edge(at_byte_edge), .busy(busy), .wel_clear(wel_clear),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  always @(posedge clk) if (mem_we) dut_mem[mem_addr] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit locked(input int page, input int lvl);
    case (lvl)
      1: return page >= 6;
      2: return page >= 4;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int mem_mismatch();
    int m = 0;
    for (int i = 0; i < MEM_N; i++) if (dut_mem[i] !== exp_mem[i]) m++;
    return m;
  endfunction

  task automatic do_write(input int page, input int off, input int n, input bit w,
                          input bit al, input bit inject, input string tag);
    bit commit;
    int bc, wc, wc_at, wec;
    commit = w && !locked(page, bp_level) && al && n > 0;
    @(posedge clk); #1;
    wel = w; wr_start = 1'b1; start_addr = ADDR_W'((page << PAGE_W) | (off % 128));
    @(posedge clk); #1;
    wr_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_data = 8'($urandom);
      byte_valid = 1'b1;
      pbuf[(off + i) % 128] = byte_data;
      @(posedge clk); #1;
    end
    byte_valid = 1'b0;
    cs_rise = 1'b1; at_byte_edge = al;
    @(posedge clk); #1;
    cs_rise = 1'b0; at_byte_edge = 1'b0;
    bc = 0; wc = 0; wc_at = 0; wec = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (busy) bc++;
      if (wel_clear) begin wc++; wc_at = bc; end
      if (mem_we) wec++;
      if (inject && bc == 10) begin
        wr_start = 1'b1; start_addr = ADDR_W'(((page ^ 1) << PAGE_W)); byte_valid = 1'b1;
        byte_data = 8'hA5; cs_rise = 1'b1; at_byte_edge = 1'b1;
      end else if (inject && bc == 11) begin
        wr_start = 1'b0; byte_valid = 1'b0; cs_rise = 1'b0; at_byte_edge = 1'b0;
      end
    end
    if (commit) for (int i = 0; i < 128; i++) exp_mem[(page << PAGE_W) + i] = pbuf[i];
    chk(bc == (commit ? BUSY_CYCLES : 0), {tag, " R8 busy length"}, bc, commit ? BUSY_CYCLES : 0);
    chk(wc == (commit ? 1 : 0), {tag, " R10 wel_clear pulses"}, wc, commit ? 1 : 0);
    if (commit) chk(wc_at == BUSY_CYCLES, {tag, " R10 wel_clear position"}, wc_at, BUSY_CYCLES);
    chk(wec == (commit ? 128 : 0), {tag, " R9 write strobes"}, wec, commit ? 128 : 0);
    chk(mem_mismatch() == 0, {tag, " array contents"}, mem_mismatch(), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < MEM_N; i++) begin dut_mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    repeat (3) @(posedge clk);
    #1;
    chk(busy == 1'b0 && wel_clear == 1'b0 && mem_we == 1'b0, "R1 reset outputs", {busy, wel_clear, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && mem_we == 1'b0, "R1 after release", {busy, mem_we}, 0);

    bp_level = 2'd0;
    do_write(1, 0, 128, 1, 1, 0, "R6 R4 aligned page");
    do_write(2, 100, 128, 1, 1, 0, "R4 offset wrap");
    do_write(3, 5, 135, 1, 1, 0, "R5 overflow");
    do_write(0, 0, 128, 0, 1, 0, "R2 no latch");
    do_write(1, 3, 128, 1, 0, 0, "R7 misaligned rise");
    do_write(1, 3, 0, 1, 1, 0, "R7 no data");
    do_write(5, 7, 128, 1, 1, 1, "R11 traffic while busy");
    bp_level = 2'd1;
    do_write(7, 0, 128, 1, 1, 0, "R3 level1 locked");
    do_write(5, 0, 128, 1, 1, 0, "R3 level1 open");
    bp_level = 2'd2;
    do_write(4, 0, 128, 1, 1, 0, "R3 level2 locked");
    do_write(3, 9, 128, 1, 1, 0, "R3 level2 open");
    bp_level = 2'd3;
    do_write(0, 0, 128, 1, 1, 0, "R3 level3 locked");

    for (int it = 0; it < 14; it++) begin
      int pg, of, nb;
      bit w, al;
      bp_level = 2'($urandom);
      pg = int'($urandom % 8);
      of = int'($urandom % 128);
      nb = 128 + int'($urandom % 40);
      w = ($urandom % 4) != 0;
      al = ($urandom % 4) != 0;
      do_write(pg, of, nb, w, al, 0, "R4 R5 R3 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule